// File: doc/BRIEF.md
# Sequential Complex Multiplier on One Multiply-Accumulate Unit

This block multiplies two complex numbers with 18-bit signed parts. For the operands (A + a·i) and (B + b·i), it returns the real part AB − ab and the imaginary part Ab + aB. It uses one multiplier feeding one accumulator over four compute clocks, so one multiplier does the work that four would do in a fully parallel design.

Each operand has a two-stage local register. Stage one keeps the real part and stage two keeps the imaginary part. Both stages load once, on the edge that accepts a start strobe. After that a small controller picks, on every clock, which stage feeds each multiplier input. It also tells the accumulator whether to load, subtract or add.

The four steps run in this order:
1. AB is loaded into the accumulator.
2. ab is subtracted, which leaves the real part.
3. Ab is loaded fresh.
4. aB is added, which gives the imaginary part.

The caller pulses `start_i` with all four components present. It then waits for a one-cycle `done_o`, which marks both results as valid together.

Top module: `cplx_seq_mul`

## Requirements
- R1: On `done_o`, `re_o` equals AB − ab as a 37-bit two's-complement value, where A = `a_re_i`, a = `a_im_i`, B = `b_re_i` and b = `b_im_i` as sampled at the accepting edge.
- R2: On `done_o`, `im_o` equals Ab + aB as a 37-bit two's-complement value.
- R3: A start is accepted at clock edge t when `start_i` is high and `busy_o` is low. `busy_o` is then high in the cycles after edges t to t+3. `done_o` is high and `busy_o` is low in the cycle after edge t+4.
- R4: The operand inputs are sampled only at the accepting edge. Changing them at any later time has no effect on the result.
- R5: `done_o` is high for exactly one cycle per accepted start. `re_o` and `im_o` hold their values until the next `done_o`.
- R6: A start strobe seen while `busy_o` is high is ignored. The running product completes unchanged and no further product begins.
- R7: All operands at −131072, and mixed extreme values, give exact results without overflow. For example, all four at −131072 gives real 0 and imaginary 2^35.
- R8: While `rst_ni` is low, `busy_o` and `done_o` are 0 and `re_o` and `im_o` are 0, even if reset arrives in the middle of a product.
- R9: A start given in the cycle where `done_o` is high is accepted. The next result follows with the same timing as in R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; accepted only when idle |
| a_re_i | input | 18 | Real part of first operand, signed |
| a_im_i | input | 18 | Imaginary part of first operand, signed |
| b_re_i | input | 18 | Real part of second operand, signed |
| b_im_i | input | 18 | Imaginary part of second operand, signed |
| busy_o | output | 1 | High while a product is in progress |
| done_o | output | 1 | One-cycle pulse when both results are valid |
| re_o | output | 37 | Real part of result, signed |
| im_o | output | 37 | Imaginary part of result, signed |

## Verification
The product is tried with the patterns below. Each one separates a different kind of mistake.
- **Small mixed-sign operands.** These catch a swapped sign in the subtract step, or a swapped stage selection, such as aB taken as ab.
- **Purely real or purely imaginary operands.** A zero operand leaves only one of the four partial products contributing. This shows which partial product ended up in which output.
- **Full-scale negative and positive extremes.** These expose truncation or a missing sign extension in the 37-bit results.
- **Garbage on the operand inputs after the start.** This separates a true one-time load from a design that reads the inputs again.
- **A start pulse during busy.** This separates an ignored start from a restart.

// File: rtl/cplx_mul_pkg.sv
package cplx_mul_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RR, ST_II, ST_RI, ST_IR
  } state_e;

  typedef enum logic [1:0] {
    MAC_HOLD, MAC_LOAD, MAC_SUB, MAC_ADD
  } mac_op_e;
endpackage

// File: rtl/operand_bank.sv
// Two-stage local operand store: stage 1 keeps the real part, stage 2 the imaginary part.
module operand_bank #(
  parameter int W = 18
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic signed [W-1:0] re_i,
  input  logic signed [W-1:0] im_i,
  input  logic                sel_i,
  output logic signed [W-1:0] opnd_o
);
  logic signed [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else if (load_i) begin
      stage1_q <= re_i;
      stage2_q <= im_i;
    end
  end

  assign opnd_o = sel_i ? stage2_q : stage1_q;

  assert_hold_operands_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(stage1_q) && $stable(stage2_q)));
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import cplx_mul_pkg::*;
#(
  parameter int OP_W  = 18,
  parameter int ACC_W = 48,
  parameter int OUT_W = 2*OP_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  mac_op_e                 op_i,
  input  logic signed [OP_W-1:0]  x_i,
  input  logic signed [OP_W-1:0]  y_i,
  output logic signed [OUT_W-1:0] acc_o,
  output logic signed [OUT_W-1:0] nxt_o
);
  localparam int PROD_W = 2*OP_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext, acc_q, acc_d;

  assign prod     = x_i * y_i;
  assign prod_ext = ACC_W'(prod);

  always_comb begin
    unique case (op_i)
      MAC_LOAD: acc_d = prod_ext;
      MAC_SUB:  acc_d = acc_q - prod_ext;
      MAC_ADD:  acc_d = acc_q + prod_ext;
      default:  acc_d = acc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign acc_o = acc_q[OUT_W-1:0];
  assign nxt_o = acc_d[OUT_W-1:0];

  // Products of OP_W-bit values never reach the unused top of the accumulator
  assert_acc_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q[ACC_W-1:OUT_W-1] == '0) || (acc_q[ACC_W-1:OUT_W-1] == '1));
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import cplx_mul_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  output logic    load_o,
  output logic    sel_x_o,
  output logic    sel_y_o,
  output mac_op_e op_o,
  output logic    cap_re_o,
  output logic    fin_o,
  output logic    busy_o
);
  state_e state_q, state_d;

  assign load_o = start_i && (state_q == ST_IDLE);
  assign busy_o = (state_q != ST_IDLE);

  always_comb begin
    state_d  = state_q;
    sel_x_o  = 1'b0;
    sel_y_o  = 1'b0;
    op_o     = MAC_HOLD;
    cap_re_o = 1'b0;
    fin_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RR;
      ST_RR: begin op_o = MAC_LOAD; state_d = ST_II; end
      ST_II: begin sel_x_o = 1'b1; sel_y_o = 1'b1; op_o = MAC_SUB; state_d = ST_RI; end
      ST_RI: begin sel_y_o = 1'b1; op_o = MAC_LOAD; cap_re_o = 1'b1; state_d = ST_IR; end
      ST_IR: begin sel_x_o = 1'b1; op_o = MAC_ADD; fin_o = 1'b1; state_d = ST_IDLE; end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assert_busy_after_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  assert_ignore_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o && !fin_o) |=> (busy_o && !load_o));
endmodule

// File: rtl/cplx_seq_mul.sv
module cplx_seq_mul
  import cplx_mul_pkg::*;
#(
  parameter int OP_W  = 18,
  parameter int ACC_W = 48,
  parameter int OUT_W = 2*OP_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic signed [OP_W-1:0]  a_re_i,
  input  logic signed [OP_W-1:0]  a_im_i,
  input  logic signed [OP_W-1:0]  b_re_i,
  input  logic signed [OP_W-1:0]  b_im_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic signed [OUT_W-1:0] re_o,
  output logic signed [OUT_W-1:0] im_o
);
  localparam int N_OPND = 2;

  logic                   load, sel_x, sel_y, cap_re, fin;
  mac_op_e                mac_op;
  logic signed [OP_W-1:0] re_in [N_OPND];
  logic signed [OP_W-1:0] im_in [N_OPND];
  logic                   sel   [N_OPND];
  logic signed [OP_W-1:0] opnd  [N_OPND];
  logic signed [OUT_W-1:0] acc, nxt, re_hold_q;

  assign re_in[0] = a_re_i;
  assign im_in[0] = a_im_i;
  assign re_in[1] = b_re_i;
  assign im_in[1] = b_im_i;
  assign sel[0]   = sel_x;
  assign sel[1]   = sel_y;

  seq_ctrl u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .load_o(load), .sel_x_o(sel_x), .sel_y_o(sel_y), .op_o(mac_op),
    .cap_re_o(cap_re), .fin_o(fin), .busy_o(busy_o)
  );

  for (genvar g = 0; g < N_OPND; g++) begin : g_bank
    operand_bank #(.W(OP_W)) u_bank (
      .clk_i, .rst_ni, .load_i(load),
      .re_i(re_in[g]), .im_i(im_in[g]), .sel_i(sel[g]), .opnd_o(opnd[g])
    );
  end

  mac_unit #(.OP_W(OP_W), .ACC_W(ACC_W), .OUT_W(OUT_W)) u_mac (
    .clk_i, .rst_ni, .op_i(mac_op), .x_i(opnd[0]), .y_i(opnd[1]),
    .acc_o(acc), .nxt_o(nxt)
  );

  // Real part parks here so both outputs change on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      re_hold_q <= '0;
      re_o      <= '0;
      im_o      <= '0;
      done_o    <= 1'b0;
    end else begin
      done_o <= fin;
      if (cap_re) re_hold_q <= acc;
      if (fin) begin
        re_o <= re_hold_q;
        im_o <= nxt;
      end
    end
  end

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_hold_result_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> ($stable(re_o) && $stable(im_o)) || done_o);
endmodule

// File: tb/cplx_seq_mul_bench.sv
module cplx_seq_mul_bench;
  localparam int OP_W = 18;
  localparam int OUT_W = 37;
  localparam int N_VEC = 6;
  localparam int VEC [N_VEC][4] = '{
    '{3, 2, 5, -4},
    '{0, 0, 0, 0},
    '{1, 0, 0, 1},
    '{-131072, -131072, -131072, -131072},
    '{131071, -131072, -131072, 131071},
    '{-7, 9, 11, -13}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic signed [OP_W-1:0] a_re_i = '0, a_im_i = '0, b_re_i = '0, b_im_i = '0;
  logic busy_o, done_o;
  logic signed [OUT_W-1:0] re_o, im_o;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  cplx_seq_mul u_cplx_seq_mul (
    .clk_i(clk), .rst_ni, .start_i, .a_re_i, .a_im_i, .b_re_i, .b_im_i,
    .busy_o, .done_o, .re_o, .im_o
  );

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Caller is just past a negedge. Returns just past the negedge of the done cycle.
  task automatic run_op(int ar, int ai, int br, int bi, bit poke);
    longint er = longint'(ar) * br - longint'(ai) * bi;
    longint ei = longint'(ar) * bi + longint'(ai) * br;
    start_i = 1'b1;
    a_re_i = OP_W'(ar); a_im_i = OP_W'(ai); b_re_i = OP_W'(br); b_im_i = OP_W'(bi);
    @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      start_i = poke && (i < 2);
      a_re_i = OP_W'($urandom); a_im_i = OP_W'($urandom);
      b_re_i = OP_W'($urandom); b_im_i = OP_W'($urandom);
      check(poke ? "R6 busy" : "R3 busy", longint'(busy_o), 1);
      check("R3 no early done", longint'(done_o), 0);
    end
    @(negedge clk);
    start_i = 1'b0;
    check("R3 done", longint'(done_o), 1);
    check("R3 busy low at done", longint'(busy_o), 0);
    check("R1 R4 real", longint'(re_o), er);
    check("R2 R4 imag", longint'(im_o), ei);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    longint held_re, held_im;
    repeat (3) @(negedge clk);
    check("R8 reset busy", longint'(busy_o), 0);
    check("R8 reset done", longint'(done_o), 0);
    check("R8 reset re", longint'(re_o), 0);
    check("R8 reset im", longint'(im_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // Table walk (R1, R2, R3, R4, R7)
    for (int v = 0; v < N_VEC; v++) begin
      run_op(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 1'b0);
      held_re = longint'(re_o);
      held_im = longint'(im_o);
      @(negedge clk);
      check("R5 single pulse", longint'(done_o), 0);
      check("R5 hold re", longint'(re_o), held_re);
      check("R5 hold im", longint'(im_o), held_im);
    end

    // R7 explicit extreme value
    run_op(-131072, -131072, -131072, -131072, 1'b0);
    check("R7 imag 2^35", longint'(im_o), 64'sd34359738368);
    check("R7 real zero", longint'(re_o), 0);
    @(negedge clk);

    // R6 start while busy ignored, no second product afterwards
    run_op(100, -200, 300, 400, 1'b1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R6 no restart busy", longint'(busy_o), 0);
      check("R6 no restart done", longint'(done_o), 0);
    end

    // R9 back-to-back: start in the done cycle
    run_op(12, 34, -56, 78, 1'b0);
    run_op(-1, -1, -1, 1, 1'b0);
    @(negedge clk);

    // R8 reset mid-product
    start_i = 1'b1;
    a_re_i = 18'sd5; a_im_i = 18'sd6; b_re_i = 18'sd7; b_im_i = 18'sd8;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R8 mid reset busy", longint'(busy_o), 0);
    check("R8 mid reset done", longint'(done_o), 0);
    check("R8 mid reset re", longint'(re_o), 0);
    check("R8 mid reset im", longint'(im_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (6) @(negedge clk);
    check("R8 no resume done", longint'(done_o), 0);
    check("R8 no resume busy", longint'(busy_o), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule